// File: doc/BRIEF.md
# Microprogram Sequencer with Subroutine Return Register

This block is the address engine of a microprogrammed control unit. It owns the control address register and a one-level subroutine return register, and it holds a writable control store of 2^ADDR_W microinstructions. In every cycle the word at the current control address is read without a clock delay and split into three micro-operation fields, a condition selector, a branch kind and a branch target. The selected status condition is evaluated and the next control address is registered on the following clock edge.

Five ways to move on are supported. A not-taken or plain step adds one to the address. A taken jump loads the target. A taken call loads the target and saves the following address. A return restores the saved address. An opcode map sends control to the four-word slot of the current instruction. The datapath supplies three status bits and the opcode. The micro-operation fields go back to a decoder outside this block. The control store is filled through a simple write port, normally while reset is held.

Top module: `mseq_sequencer`

## Requirements
- R1: While `rst_n` is low, each clock edge sets `ctl_addr` to FETCH_ADDR (64) and clears the return register. A return executed as the first step after reset therefore goes to address 0.
- R2: The word at `ctl_addr` is 20 bits wide. Bits [19:17] appear on `uop_a`, bits [16:14] on `uop_b` and bits [13:11] on `uop_c` in the same cycle. Bits [10:9] are the condition selector, bits [8:7] the branch kind and bits [6:0] the target.
- R3: Branch kind 00 (jump) with a true condition sets `ctl_addr` to the target field on the next edge.
- R4: The condition selector picks 00 = always true, 01 = `st_ind`, 10 = `st_sign`, 11 = `st_zero`. For a jump or a call whose condition is false, the next address is the current address plus one.
- R5: Branch kind 01 (call) with a true condition loads the target and saves the current address plus one. A later return (kind 10) goes back to that saved address.
- R6: A call whose condition is false leaves the return register unchanged.
- R7: Branch kind 11 (map) loads `{1'b0, opcode, 2'b00}`. It ignores both the target field and the condition.
- R8: A return ignores the target field and the condition.
- R9: Incrementing from the last address (127) wraps to 0.
- R10: When `ld_en` is high at a clock edge, `ld_word` is written to control-store address `ld_addr`. The word is read back at that address whenever `ctl_addr` points to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Control-store write enable |
| ld_addr | input | 7 | Control-store write address |
| ld_word | input | 20 | Microinstruction to write |
| opcode | input | 4 | Instruction opcode used by map |
| st_ind | input | 1 | Indirect-address status bit |
| st_sign | input | 1 | Sign status bit |
| st_zero | input | 1 | Zero status bit |
| uop_a | output | 3 | First micro-operation field |
| uop_b | output | 3 | Second micro-operation field |
| uop_c | output | 3 | Third micro-operation field |
| ctl_addr | output | 7 | Current control address |

## Verification
The bench builds the block with its default parameters: a 7-bit control address, a 4-bit opcode, a map shift of two and fetch entry 64. This gives the full 128-word store, so the wrap from 127 to 0 can be reached directly. The map test sweeps all sixteen opcodes, each with a condition that is false and a target that is not zero, to show that map reaches every four-word slot in the lower half. Call, return and not-taken call are chained in one routine, so the saved return address is observed only through where control goes next.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
   localparam int UOP_W = 3;
   localparam int CD_W  = 2;
   localparam int BR_W  = 2;

   typedef enum logic [CD_W-1:0] {
      CD_ALWAYS = 2'b00,
      CD_IND    = 2'b01,
      CD_SIGN   = 2'b10,
      CD_ZERO   = 2'b11
   } cond_sel_e;

   typedef enum logic [BR_W-1:0] {
      BR_JMP  = 2'b00,
      BR_CALL = 2'b01,
      BR_RET  = 2'b10,
      BR_MAP  = 2'b11
   } br_kind_e;
endpackage

// File: rtl/mseq_store.sv
module mseq_store #(
   parameter int ADDR_W = 7,
   parameter int WORD_W = 20,
   localparam int DEPTH = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   // asynchronous read: the word at the current address is visible this cycle
   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mseq_field_split.sv
module mseq_field_split
   import mseq_pkg::*;
#(
   parameter int ADDR_W = 7,
   localparam int WORD_W = 3*UOP_W + CD_W + BR_W + ADDR_W
) (
   input  logic [WORD_W-1:0] word,
   output logic [UOP_W-1:0]  uop_a,
   output logic [UOP_W-1:0]  uop_b,
   output logic [UOP_W-1:0]  uop_c,
   output cond_sel_e         cd,
   output br_kind_e          br,
   output logic [ADDR_W-1:0] ad
);
   localparam int AD_LSB = 0;
   localparam int BR_LSB = AD_LSB + ADDR_W;
   localparam int CD_LSB = BR_LSB + BR_W;
   localparam int UC_LSB = CD_LSB + CD_W;
   localparam int UB_LSB = UC_LSB + UOP_W;
   localparam int UA_LSB = UB_LSB + UOP_W;

   assign ad    = word[AD_LSB +: ADDR_W];
   assign br    = br_kind_e'(word[BR_LSB +: BR_W]);
   assign cd    = cond_sel_e'(word[CD_LSB +: CD_W]);
   assign uop_c = word[UC_LSB +: UOP_W];
   assign uop_b = word[UB_LSB +: UOP_W];
   assign uop_a = word[UA_LSB +: UOP_W];
endmodule

// File: rtl/mseq_cond_sel.sv
module mseq_cond_sel
   import mseq_pkg::*;
(
   input  cond_sel_e cd,
   input  logic      st_ind,
   input  logic      st_sign,
   input  logic      st_zero,
   output logic      cond_true
);
   localparam int NSRC = 1 << CD_W;
   logic [NSRC-1:0] src;
   logic [NSRC-1:0] hit;

   assign src = {st_zero, st_sign, st_ind, 1'b1};

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign hit[i] = (cd == cond_sel_e'(i)) & src[i];
   end

   assign cond_true = |hit;
endmodule

// File: rtl/mseq_next_addr.sv
module mseq_next_addr
   import mseq_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int OPC_W   = 4,
   parameter int MAP_LSB = 2
) (
   input  logic [ADDR_W-1:0] car,
   input  logic [ADDR_W-1:0] sbr,
   input  logic [ADDR_W-1:0] ad,
   input  logic [OPC_W-1:0]  opcode,
   input  br_kind_e          br,
   input  logic              cond_true,
   output logic [ADDR_W-1:0] car_nxt,
   output logic              sbr_we,
   output logic [ADDR_W-1:0] sbr_nxt
);
   logic [ADDR_W-1:0] car_inc;
   logic [ADDR_W-1:0] map_addr;

   assign car_inc  = ADDR_W'(car + 1'b1);
   assign map_addr = ADDR_W'({opcode, {MAP_LSB{1'b0}}});
   assign sbr_nxt  = car_inc;

   always_comb begin
      car_nxt = car_inc;
      sbr_we  = 1'b0;
      unique case (br)
         BR_JMP:  if (cond_true) car_nxt = ad;
         BR_CALL: if (cond_true) begin
            car_nxt = ad;
            sbr_we  = 1'b1;
         end
         BR_RET:  car_nxt = sbr;
         BR_MAP:  car_nxt = map_addr;
         default: car_nxt = car_inc;
      endcase
   end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
   import mseq_pkg::*;
#(
   parameter int ADDR_W     = 7,
   parameter int OPC_W      = 4,
   parameter int MAP_LSB    = 2,
   parameter int FETCH_ADDR = 64,
   localparam int WORD_W    = 3*UOP_W + CD_W + BR_W + ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [WORD_W-1:0] ld_word,
   input  logic [OPC_W-1:0]  opcode,
   input  logic              st_ind,
   input  logic              st_sign,
   input  logic              st_zero,
   output logic [UOP_W-1:0]  uop_a,
   output logic [UOP_W-1:0]  uop_b,
   output logic [UOP_W-1:0]  uop_c,
   output logic [ADDR_W-1:0] ctl_addr
);
   if (OPC_W + MAP_LSB >= ADDR_W) begin : g_bad_map
      $error("map slot must fit in the lower half of the store");
   end
   if (FETCH_ADDR >= (1 << ADDR_W) || FETCH_ADDR < 0) begin : g_bad_fetch
      $error("fetch entry outside the control store");
   end

   logic [ADDR_W-1:0] car_q;
   logic [ADDR_W-1:0] sbr_q;
   logic [ADDR_W-1:0] car_nxt;
   logic [ADDR_W-1:0] sbr_nxt;
   logic              sbr_we;
   logic [WORD_W-1:0] cur_word;
   cond_sel_e         cd_sel;
   br_kind_e          br_kind;
   logic [ADDR_W-1:0] ad_fld;
   logic              cond_true;

   mseq_store #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) i_store (
      .clk     (clk),
      .wr_en   (ld_en),
      .wr_addr (ld_addr),
      .wr_data (ld_word),
      .rd_addr (car_q),
      .rd_data (cur_word)
   );

   mseq_field_split #(.ADDR_W(ADDR_W)) i_split (
      .word  (cur_word),
      .uop_a (uop_a),
      .uop_b (uop_b),
      .uop_c (uop_c),
      .cd    (cd_sel),
      .br    (br_kind),
      .ad    (ad_fld)
   );

   mseq_cond_sel i_cond (
      .cd        (cd_sel),
      .st_ind    (st_ind),
      .st_sign   (st_sign),
      .st_zero   (st_zero),
      .cond_true (cond_true)
   );

   mseq_next_addr #(.ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_LSB(MAP_LSB)) i_next (
      .car       (car_q),
      .sbr       (sbr_q),
      .ad        (ad_fld),
      .opcode    (opcode),
      .br        (br_kind),
      .cond_true (cond_true),
      .car_nxt   (car_nxt),
      .sbr_we    (sbr_we),
      .sbr_nxt   (sbr_nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         car_q <= ADDR_W'(FETCH_ADDR);
         sbr_q <= '0;
      end else begin
         car_q <= car_nxt;
         if (sbr_we) sbr_q <= sbr_nxt;
      end
   end

   assign ctl_addr = car_q;
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker
   import mseq_pkg::*;
#(
   parameter int ADDR_W  = 7,
   parameter int OPC_W   = 4,
   parameter int MAP_LSB = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] ctl_addr,
   input logic [ADDR_W-1:0] sbr,
   input logic [OPC_W-1:0]  opcode,
   input logic              st_ind,
   input logic              st_sign,
   input logic              st_zero,
   input logic [CD_W-1:0]   cd,
   input logic [BR_W-1:0]   br,
   input logic [ADDR_W-1:0] ad
);
   logic c_ok;
   always_comb begin
      case (cd)
         2'b00:   c_ok = 1'b1;
         2'b01:   c_ok = st_ind;
         2'b10:   c_ok = st_sign;
         default: c_ok = st_zero;
      endcase
   end

   p_jmp_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (br == 2'b00 && c_ok) |=> ctl_addr == $past(ad));

   p_not_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((br == 2'b00 || br == 2'b01) && !c_ok) |=> ctl_addr == ADDR_W'($past(ctl_addr) + 1'b1));

   p_call_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (br == 2'b01 && c_ok) |=> (sbr == ADDR_W'($past(ctl_addr) + 1'b1) && ctl_addr == $past(ad)));

   p_sbr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(br == 2'b01 && c_ok) |=> $stable(sbr));

   p_map_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (br == 2'b11) |=> ctl_addr == ADDR_W'({$past(opcode), {MAP_LSB{1'b0}}}));

   p_ret_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (br == 2'b10) |=> ctl_addr == $past(sbr));
endmodule

bind mseq_sequencer mseq_checker #(
   .ADDR_W(ADDR_W), .OPC_W(OPC_W), .MAP_LSB(MAP_LSB)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ctl_addr (ctl_addr),
   .sbr      (sbr_q),
   .opcode   (opcode),
   .st_ind   (st_ind),
   .st_sign  (st_sign),
   .st_zero  (st_zero),
   .cd       (cd_sel),
   .br       (br_kind),
   .ad       (ad_fld)
);

// File: tb/test_mseq_sequencer.sv
module test_mseq_sequencer;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ld_en = 1'b0;
   logic [6:0] ld_addr = '0;
   logic [19:0] ld_word = '0;
   logic [3:0] opcode = '0;
   logic       st_ind = 1'b0, st_sign = 1'b0, st_zero = 1'b0;
   logic [2:0] uop_a, uop_b, uop_c;
   logic [6:0] ctl_addr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mseq_sequencer i_mseq_sequencer (
      .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
      .opcode(opcode), .st_ind(st_ind), .st_sign(st_sign), .st_zero(st_zero),
      .uop_a(uop_a), .uop_b(uop_b), .uop_c(uop_c), .ctl_addr(ctl_addr)
   );

   function automatic logic [19:0] mk(input logic [2:0] a, input logic [2:0] b,
                                      input logic [2:0] c, input logic [1:0] cd,
                                      input logic [1:0] br, input logic [6:0] ad);
      return {a, b, c, cd, br, ad};
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic load(input logic [6:0] a, input logic [19:0] w);
      ld_en = 1'b1; ld_addr = a; ld_word = w;
      step();
      ld_en = 1'b0;
   endtask

   task automatic enter_reset();
      @(negedge clk);
      rst_n = 1'b0;
      step();
   endtask

   task automatic leave_reset();
      rst_n = 1'b1;
   endtask

   task automatic t_reset();
      enter_reset();
      chk("R1 reset address", ctl_addr, 64);
      load(7'd64, mk(0, 0, 0, 2'b11, 2'b10, 7'd33));
      leave_reset();
      step();
      chk("R1 return after reset", ctl_addr, 0);
   endtask

   task automatic t_fields();
      enter_reset();
      load(7'd64, mk(3'd6, 3'd5, 3'd3, 2'b00, 2'b00, 7'd64));
      step();
      chk("R2 R10 uop_a", uop_a, 6);
      chk("R2 R10 uop_b", uop_b, 5);
      chk("R2 R10 uop_c", uop_c, 3);
   endtask

   task automatic t_jump();
      enter_reset();
      load(7'd64, mk(0, 0, 0, 2'b00, 2'b00, 7'd10));
      load(7'd10, mk(0, 0, 0, 2'b01, 2'b00, 7'd20));
      load(7'd20, mk(0, 0, 0, 2'b10, 2'b00, 7'd30));
      load(7'd21, mk(0, 0, 0, 2'b11, 2'b00, 7'd40));
      load(7'd40, mk(0, 0, 0, 2'b10, 2'b00, 7'd5));
      load(7'd5,  mk(0, 0, 0, 2'b11, 2'b00, 7'd7));
      st_ind = 1'b1; st_sign = 1'b0; st_zero = 1'b1;
      leave_reset();
      step(); chk("R3 unconditional jump", ctl_addr, 10);
      step(); chk("R3 R4 jump on ind", ctl_addr, 20);
      step(); chk("R4 sign false steps", ctl_addr, 21);
      step(); chk("R4 jump on zero", ctl_addr, 40);
      st_sign = 1'b1; st_zero = 1'b0;
      step(); chk("R4 jump on sign", ctl_addr, 5);
      step(); chk("R4 zero false steps", ctl_addr, 6);
      st_ind = 1'b0; st_sign = 1'b0;
   endtask

   task automatic t_call();
      enter_reset();
      load(7'd64, mk(0, 0, 0, 2'b00, 2'b01, 7'd67));
      load(7'd67, mk(0, 0, 0, 2'b11, 2'b10, 7'd99));
      load(7'd65, mk(0, 0, 0, 2'b01, 2'b01, 7'd67));
      load(7'd66, mk(0, 0, 0, 2'b00, 2'b10, 7'd12));
      st_ind = 1'b0; st_zero = 1'b0;
      leave_reset();
      step(); chk("R5 call taken", ctl_addr, 67);
      step(); chk("R5 R8 return to saved", ctl_addr, 65);
      step(); chk("R6 call not taken steps", ctl_addr, 66);
      step(); chk("R6 return register kept", ctl_addr, 65);
   endtask

   task automatic t_map();
      for (int op = 0; op < 16; op++) begin
         enter_reset();
         if (op == 0) load(7'd64, mk(0, 0, 0, 2'b01, 2'b11, 7'h55));
         opcode = 4'(op);
         st_ind = 1'b0;
         leave_reset();
         step();
         chk("R7 map slot", ctl_addr, op * 4);
      end
   endtask

   task automatic t_wrap();
      enter_reset();
      load(7'd64, mk(0, 0, 0, 2'b00, 2'b00, 7'd127));
      load(7'd127, mk(0, 0, 0, 2'b11, 2'b00, 7'd3));
      st_zero = 1'b0;
      leave_reset();
      step(); chk("R9 reach last", ctl_addr, 127);
      step(); chk("R9 wrap to zero", ctl_addr, 0);
   endtask

   initial begin
      t_reset();
      t_fields();
      t_jump();
      t_call();
      t_map();
      t_wrap();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule